// File: doc/BRIEF.md
# Bus Access Protection Checker

This block watches every bus access issued by up to three bus masters and decides, in the same cycle, whether the access is legal. It keeps a bank of programmable address-range descriptors. Each descriptor holds an inclusive lower and upper bound on a 23-bit global address, a per-master select mask, and two restriction bits: write-protect and no-execute. An access is legal only when some enabled descriptor for its master covers the address and no covering descriptor forbids the kind of access being made.

Two fixed rules override the descriptors. The first covers the small bank-select register window at addresses 0x0010 to 0x0017: the main CPU always has access and the other masters never do. The second covers the peripheral register space: while the sticky error flag is set, the main CPU in supervisor state may read and write that space. This lets the error handler clear the flag even when the descriptors lock the space.

Any illegal access raises a violation output in the same cycle and sets the sticky error flag on the next clock edge. The master ID and the faulting address are also captured. Software clears the flag by writing a one to the clear input. Descriptors are loaded one at a time through a simple write port.

Top module: `mem_prot_checker`

## Requirements
- R1: A descriptor covers an access when lower ≤ address ≤ upper (both inclusive) and the mask bit at the access's master ID is set. Master ID 0 is the main CPU, 1 is the second master and 2 is the third. ID 3 is matched by no descriptor. A descriptor write through the configuration port takes effect from the next cycle.
- R2: A descriptor whose lower bound is greater than its upper bound matches no address.
- R3: When several descriptors cover an access for its master, the effective write-protect is the OR of their write-protect bits, and the effective no-execute is the OR of their no-execute bits.
- R4: A write (accWrite=1) whose effective write-protect is 1 is a violation. Reads of a covered address are never rejected for write-protect.
- R5: An opcode fetch (accFetch=1, prefetches included) whose effective no-execute is 1 is a violation.
- R6: Outside the fixed rules, an access that no descriptor covers for its master is a violation.
- R7: Addresses 0x0010 to 0x0017 are always legal for master 0 and always a violation for masters 1 and 2, whatever the descriptors say.
- R8: While errFlag=1, a non-fetch access by master 0 with accSuper=1 to addresses 0x0000 to 0x07FF is legal. When errFlag=0, or in user state, the descriptors decide.
- R9: violation is combinational, is high only while accValid=1, and errFlag is 1 after the clock edge that ends a violating access.
- R10: errFlag stays set until a cycle with flagClr=1. If a violation and flagClr occur in the same cycle, the flag stays set.
- R11: On a violation, errMaster and errAddr load the access's master and address if errFlag is clear or is being cleared in that cycle. Otherwise they keep the first fault.
- R12: After reset, errFlag, errMaster and errAddr are 0 and every descriptor is disabled, so every access outside the page window is a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Descriptor write strobe |
| cfgIdx | input | 3 | Descriptor index to write |
| cfgLo | input | 23 | Inclusive lower bound |
| cfgHi | input | 23 | Inclusive upper bound |
| cfgMask | input | 3 | Master select mask, bit n for master n |
| cfgWp | input | 1 | Write-protect bit |
| cfgNex | input | 1 | No-execute bit |
| accValid | input | 1 | An access is presented this cycle |
| accMaster | input | 2 | Master ID of the access |
| accSuper | input | 1 | 1 = supervisor state |
| accAddr | input | 23 | Global address of the access |
| accWrite | input | 1 | 1 = write |
| accFetch | input | 1 | 1 = opcode fetch or prefetch |
| flagClr | input | 1 | Write-one-to-clear for errFlag |
| violation | output | 1 | Illegal access in this cycle |
| errFlag | output | 1 | Sticky access-error flag |
| errMaster | output | 2 | Master ID of the captured fault |
| errAddr | output | 23 | Address of the captured fault |

## Verification
The bench builds the block with its default parameters: eight descriptors, three masters and a 23-bit address. With these values it can set up two overlapping ranges, one range with inverted bounds, ranges that only one master selects, and a locked peripheral space, all at once, and still have one descriptor left that stays disabled from reset. The page window and the peripheral limit keep their default addresses. This lets the fixed rules be tried against descriptors that would grant or deny the same access. The flag-dependent peripheral rule, same-cycle clear and set, and first-fault retention are driven as directed sequences.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  // Strobes from rule control to the datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic capture;
  } mpu_strobe_t;

  localparam int unsigned MASTER_CPU = 0;

endpackage

// File: rtl/mpu_range_cmp.sv
module mpu_range_cmp #(
  parameter int unsigned AW = 23,
  parameter int unsigned NM = 3,
  parameter int unsigned MW = 2
) (
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [NM-1:0] mask,
  input  logic          wp,
  input  logic          nex,
  input  logic [AW-1:0] addr,
  input  logic [MW-1:0] master,
  output logic          hit,
  output logic          hitWp,
  output logic          hitNex
);

  logic boundsOk;
  logic inRange;
  logic selected;

  assign boundsOk = (lo <= hi);
  assign inRange  = (addr >= lo) && (addr <= hi);

  always_comb begin
    selected = 1'b0;
    for (int m = 0; m < NM; m++) begin
      if (master == MW'(m) && mask[m]) selected = 1'b1;
    end
  end

  assign hit    = boundsOk && inRange && selected;
  assign hitWp  = hit && wp;
  assign hitNex = hit && nex;

endmodule

// File: rtl/mpu_datapath.sv
module mpu_datapath
  import mpu_pkg::*;
#(
  parameter int unsigned AW = 23,
  parameter int unsigned NM = 3,
  parameter int unsigned MW = 2,
  parameter int unsigned ND = 8,
  localparam int unsigned IW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [IW-1:0] cfgIdx,
  input  logic [AW-1:0] cfgLo,
  input  logic [AW-1:0] cfgHi,
  input  logic [NM-1:0] cfgMask,
  input  logic          cfgWp,
  input  logic          cfgNex,
  input  logic [AW-1:0] accAddr,
  input  logic [MW-1:0] accMaster,
  input  mpu_strobe_t   strobe,
  output logic          anyHit,
  output logic          effWp,
  output logic          effNex,
  output logic          errFlag,
  output logic [MW-1:0] errMaster,
  output logic [AW-1:0] errAddr
);

  logic [ND-1:0] hitVec;
  logic [ND-1:0] wpVec;
  logic [ND-1:0] nexVec;

  for (genvar d = 0; d < ND; d++) begin : g_desc
    logic [AW-1:0] loQ;
    logic [AW-1:0] hiQ;
    logic [NM-1:0] maskQ;
    logic          wpQ;
    logic          nexQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loQ   <= '1;
        hiQ   <= '0;
        maskQ <= '0;
        wpQ   <= 1'b0;
        nexQ  <= 1'b0;
      end else if (cfgWrEn && cfgIdx == IW'(d)) begin
        loQ   <= cfgLo;
        hiQ   <= cfgHi;
        maskQ <= cfgMask;
        wpQ   <= cfgWp;
        nexQ  <= cfgNex;
      end
    end

    mpu_range_cmp #(
      .AW(AW), .NM(NM), .MW(MW)
    ) i_cmp (
      .lo    (loQ),
      .hi    (hiQ),
      .mask  (maskQ),
      .wp    (wpQ),
      .nex   (nexQ),
      .addr  (accAddr),
      .master(accMaster),
      .hit   (hitVec[d]),
      .hitWp (wpVec[d]),
      .hitNex(nexVec[d])
    );
  end

  assign anyHit = |hitVec;
  assign effWp  = |wpVec;
  assign effNex = |nexVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobe.setFlag) begin
      errFlag <= 1'b1;
    end else if (strobe.clrFlag) begin
      errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errMaster <= '0;
      errAddr   <= '0;
    end else if (strobe.capture) begin
      errMaster <= accMaster;
      errAddr   <= accAddr;
    end
  end

endmodule

// File: rtl/mpu_control.sv
module mpu_control
  import mpu_pkg::*;
#(
  parameter int unsigned AW = 23,
  parameter int unsigned MW = 2,
  parameter logic [AW-1:0] PAGE_LO = 'h10,
  parameter logic [AW-1:0] PAGE_HI = 'h17,
  parameter logic [AW-1:0] PERIPH_HI = 'h7FF
) (
  input  logic          accValid,
  input  logic [MW-1:0] accMaster,
  input  logic          accSuper,
  input  logic [AW-1:0] accAddr,
  input  logic          accWrite,
  input  logic          accFetch,
  input  logic          anyHit,
  input  logic          effWp,
  input  logic          effNex,
  input  logic          errFlag,
  input  logic          flagClr,
  output logic          violation,
  output mpu_strobe_t   strobe
);

  logic inPage;
  logic inPeriph;
  logic isCpu;
  logic allow;

  assign inPage   = (accAddr >= PAGE_LO) && (accAddr <= PAGE_HI);
  assign inPeriph = (accAddr <= PERIPH_HI);
  assign isCpu    = (accMaster == MW'(MASTER_CPU));

  always_comb begin
    if (inPage) begin
      allow = isCpu;
    end else if (errFlag && isCpu && accSuper && !accFetch && inPeriph) begin
      allow = 1'b1;
    end else begin
      allow = anyHit && !(accWrite && effWp) && !(accFetch && effNex);
    end
  end

  assign violation = accValid && !allow;

  always_comb begin
    strobe.setFlag = violation;
    strobe.clrFlag = flagClr;
    strobe.capture = violation && (!errFlag || flagClr);
  end

endmodule

// File: rtl/mem_prot_checker.sv
module mem_prot_checker
  import mpu_pkg::*;
#(
  parameter int unsigned AW = 23,
  parameter int unsigned NM = 3,
  parameter int unsigned MW = 2,
  parameter int unsigned ND = 8,
  parameter logic [AW-1:0] PAGE_LO = 'h10,
  parameter logic [AW-1:0] PAGE_HI = 'h17,
  parameter logic [AW-1:0] PERIPH_HI = 'h7FF,
  localparam int unsigned IW = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [IW-1:0] cfgIdx,
  input  logic [AW-1:0] cfgLo,
  input  logic [AW-1:0] cfgHi,
  input  logic [NM-1:0] cfgMask,
  input  logic          cfgWp,
  input  logic          cfgNex,
  input  logic          accValid,
  input  logic [MW-1:0] accMaster,
  input  logic          accSuper,
  input  logic [AW-1:0] accAddr,
  input  logic          accWrite,
  input  logic          accFetch,
  input  logic          flagClr,
  output logic          violation,
  output logic          errFlag,
  output logic [MW-1:0] errMaster,
  output logic [AW-1:0] errAddr
);

  mpu_strobe_t strobe;
  logic        anyHit;
  logic        effWp;
  logic        effNex;

  mpu_datapath #(
    .AW(AW), .NM(NM), .MW(MW), .ND(ND)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgIdx   (cfgIdx),
    .cfgLo    (cfgLo),
    .cfgHi    (cfgHi),
    .cfgMask  (cfgMask),
    .cfgWp    (cfgWp),
    .cfgNex   (cfgNex),
    .accAddr  (accAddr),
    .accMaster(accMaster),
    .strobe   (strobe),
    .anyHit   (anyHit),
    .effWp    (effWp),
    .effNex   (effNex),
    .errFlag  (errFlag),
    .errMaster(errMaster),
    .errAddr  (errAddr)
  );

  mpu_control #(
    .AW(AW), .MW(MW),
    .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI), .PERIPH_HI(PERIPH_HI)
  ) i_control (
    .accValid (accValid),
    .accMaster(accMaster),
    .accSuper (accSuper),
    .accAddr  (accAddr),
    .accWrite (accWrite),
    .accFetch (accFetch),
    .anyHit   (anyHit),
    .effWp    (effWp),
    .effNex   (effNex),
    .errFlag  (errFlag),
    .flagClr  (flagClr),
    .violation(violation),
    .strobe   (strobe)
  );

endmodule

// File: rtl/mem_prot_checker_sva.sv
module mem_prot_checker_sva #(
  parameter int unsigned AW = 23,
  parameter int unsigned MW = 2,
  parameter logic [AW-1:0] PAGE_LO = 'h10,
  parameter logic [AW-1:0] PAGE_HI = 'h17,
  parameter logic [AW-1:0] PERIPH_HI = 'h7FF
) (
  input logic          clk,
  input logic          rstN,
  input logic          accValid,
  input logic [MW-1:0] accMaster,
  input logic          accSuper,
  input logic [AW-1:0] accAddr,
  input logic          accFetch,
  input logic          flagClr,
  input logic          violation,
  input logic          errFlag,
  input logic [MW-1:0] errMaster,
  input logic [AW-1:0] errAddr
);

  logic pageHit;
  assign pageHit = accValid && (accAddr >= PAGE_LO) && (accAddr <= PAGE_HI);

  AST_VIOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> accValid); // R9
  AST_FLAG_AFTER_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> errFlag); // R9
  AST_PAGE_CPU_OK: assert property (@(posedge clk) disable iff (!rstN)
    (pageHit && accMaster == '0) |-> !violation); // R7
  AST_PAGE_OTHER_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (pageHit && accMaster != '0) |-> violation); // R7
  AST_PERIPH_RESCUE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && errFlag && accMaster == '0 && accSuper && !accFetch
     && accAddr <= PERIPH_HI) |-> !violation); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !flagClr) |=> errFlag); // R10
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !violation) |=> !errFlag); // R10
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !flagClr) |=> ($stable(errAddr) && $stable(errMaster))); // R11

endmodule

bind mem_prot_checker mem_prot_checker_sva #(
  .AW(AW), .MW(MW), .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI), .PERIPH_HI(PERIPH_HI)
) i_sva (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accMaster(accMaster),
  .accSuper (accSuper),
  .accAddr  (accAddr),
  .accFetch (accFetch),
  .flagClr  (flagClr),
  .violation(violation),
  .errFlag  (errFlag),
  .errMaster(errMaster),
  .errAddr  (errAddr)
);

// File: tb/test_mem_prot_checker.sv
module test_mem_prot_checker;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int NM = 3;
  localparam int MW = 2;
  localparam int ND = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [AW-1:0] cfgLo = '0;
  logic [AW-1:0] cfgHi = '0;
  logic [NM-1:0] cfgMask = '0;
  logic          cfgWp = 1'b0;
  logic          cfgNex = 1'b0;
  logic          accValid = 1'b0;
  logic [MW-1:0] accMaster = '0;
  logic          accSuper = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic          accWrite = 1'b0;
  logic          accFetch = 1'b0;
  logic          flagClr = 1'b0;
  logic          violation;
  logic          errFlag;
  logic [MW-1:0] errMaster;
  logic [AW-1:0] errAddr;

  int checks = 0;
  int failures = 0;
  logic v;

  mem_prot_checker #(.AW(AW), .NM(NM), .MW(MW), .ND(ND)) i_mem_prot_checker (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgLo(cfgLo),
    .cfgHi(cfgHi), .cfgMask(cfgMask), .cfgWp(cfgWp), .cfgNex(cfgNex),
    .accValid(accValid), .accMaster(accMaster), .accSuper(accSuper),
    .accAddr(accAddr), .accWrite(accWrite), .accFetch(accFetch),
    .flagClr(flagClr), .violation(violation), .errFlag(errFlag),
    .errMaster(errMaster), .errAddr(errAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Vector: {req[3:0], master[1:0], super, write, fetch, expViol, addr[22:0]}
  localparam int NV = 25;
  localparam logic [32:0] VECS [NV] = '{
    {4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 23'h400100}, // R1 read in d0
    {4'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 23'h400100}, // R4 write WP
    {4'd5, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 23'h400100}, // R5 fetch allowed
    {4'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 23'h418000}, // R3 overlap WP
    {4'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 23'h418000}, // R3 overlap NEX
    {4'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 23'h418000}, // R3 overlap read
    {4'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 23'h420000}, // R4 write in d1 only
    {4'd5, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 23'h420000}, // R5 prefetch in NEX
    {4'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 23'h43FFFF}, // R1 upper bound inclusive
    {4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 23'h440000}, // R1 just above
    {4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 23'h3FFFFF}, // R1 just below
    {4'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 23'h41FFFF}, // R3 overlap top
    {4'd7, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 23'h000012}, // R7 CPU write page
    {4'd7, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 23'h000010}, // R7 master1 page
    {4'd7, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 23'h000017}, // R7 master2 page
    {4'd7, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 23'h000018}, // R7 just past page
    {4'd8, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 23'h000100}, // R8 flag clear
    {4'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 23'h200000}, // R2 inverted
    {4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 23'h300010}, // R1 mask excludes CPU
    {4'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 23'h300010}, // R1 mask selects master1
    {4'd5, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 23'h500000}, // R5 master2 prefetch
    {4'd4, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 23'h500000}, // R4 master2 write
    {4'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 23'h001000}, // R1 shared range
    {4'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 23'h001000}, // R1 ID 3 never matches
    {4'd6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 23'h7FFFFF}  // R6 no descriptor
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic progDesc(input int idx, input logic [AW-1:0] lo,
                          input logic [AW-1:0] hi, input logic [NM-1:0] mask,
                          input logic wp, input logic nex);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = IW'(idx); cfgLo = lo; cfgHi = hi;
    cfgMask = mask; cfgWp = wp; cfgNex = nex;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic drive(input logic [MW-1:0] m, input logic s, input logic [AW-1:0] a,
                       input logic w, input logic f, output logic vOut);
    @(negedge clk);
    accValid = 1'b1; accMaster = m; accSuper = s; accAddr = a;
    accWrite = w; accFetch = f;
    #1 vOut = violation;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; accFetch = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(errFlag == 1'b0, "R12 flag after reset", 32'(errFlag), 0);
    check(errAddr == '0, "R12 errAddr after reset", 32'(errAddr), 0);
    check(errMaster == '0, "R12 errMaster after reset", 32'(errMaster), 0);
    check(violation == 1'b0, "R9 idle no violation", 32'(violation), 0);
    rstN = 1'b1;
    drive(2'd1, 1'b1, 23'h001000, 1'b0, 1'b0, v);
    check(v == 1'b1, "R12 descriptors disabled at reset", 32'(v), 1);
    drive(2'd0, 1'b0, 23'h000013, 1'b0, 1'b0, v);
    check(v == 1'b0, "R7 page window with empty bank", 32'(v), 0);

    progDesc(0, 23'h400000, 23'h41FFFF, 3'b001, 1'b1, 1'b0);
    progDesc(1, 23'h410000, 23'h43FFFF, 3'b001, 1'b0, 1'b1);
    progDesc(2, 23'h000800, 23'h00FFFF, 3'b111, 1'b0, 1'b0);
    progDesc(3, 23'h000000, 23'h0007FF, 3'b111, 1'b1, 1'b1);
    progDesc(4, 23'h200000, 23'h1FFFFF, 3'b111, 1'b0, 1'b0);
    progDesc(5, 23'h300000, 23'h30FFFF, 3'b010, 1'b0, 1'b0);
    progDesc(6, 23'h500000, 23'h50FFFF, 3'b100, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] vec;
      string tag;
      vec = VECS[i];
      tag = $sformatf("R%0d vector %0d", vec[32:29], i);
      clearFlag();
      drive(vec[28:27], vec[26], vec[22:0], vec[25], vec[24], v);
      check(v == vec[23], tag, 32'(v), 32'(vec[23]));
      check(errFlag == vec[23], {tag, " flag (R9)"}, 32'(errFlag), 32'(vec[23]));
      if (vec[23]) begin
        check(errAddr == vec[22:0], {tag, " addr (R11)"}, 32'(errAddr), 32'(vec[22:0]));
        check(errMaster == vec[28:27], {tag, " master (R11)"}, 32'(errMaster),
              32'(vec[28:27]));
      end
    end

    // R8 peripheral rescue while flag set
    clearFlag();
    drive(2'd0, 1'b1, 23'h000100, 1'b1, 1'b0, v);
    check(v == 1'b1, "R8 locked while flag clear", 32'(v), 1);
    drive(2'd0, 1'b1, 23'h000200, 1'b1, 1'b0, v);
    check(v == 1'b0, "R8 supervisor write while flag set", 32'(v), 0);
    drive(2'd0, 1'b0, 23'h000204, 1'b1, 1'b0, v);
    check(v == 1'b1, "R8 user write while flag set", 32'(v), 1);
    check(errAddr == 23'h000100, "R11 first fault kept", 32'(errAddr), 32'h100);
    drive(2'd1, 1'b1, 23'h000300, 1'b1, 1'b0, v);
    check(v == 1'b1, "R8 other master not rescued", 32'(v), 1);
    drive(2'd0, 1'b1, 23'h000200, 1'b0, 1'b1, v);
    check(v == 1'b1, "R8 fetch not rescued", 32'(v), 1);
    check(errMaster == 2'd0, "R11 first master kept", 32'(errMaster), 0);

    // R10 clear, then rule lapses
    clearFlag();
    check(errFlag == 1'b0, "R10 flag cleared", 32'(errFlag), 0);
    drive(2'd0, 1'b1, 23'h000200, 1'b1, 1'b0, v);
    check(v == 1'b1, "R8 rescue ends after clear", 32'(v), 1);

    // R10/R11 clear and violation in same cycle
    @(negedge clk);
    flagClr = 1'b1; accValid = 1'b1; accMaster = 2'd2; accSuper = 1'b0;
    accAddr = 23'h200000; accWrite = 1'b0; accFetch = 1'b0;
    @(negedge clk);
    flagClr = 1'b0; accValid = 1'b0;
    check(errFlag == 1'b1, "R10 set wins over clear", 32'(errFlag), 1);
    check(errAddr == 23'h200000, "R11 capture on clear cycle", 32'(errAddr), 32'h200000);
    check(errMaster == 2'd2, "R11 master on clear cycle", 32'(errMaster), 2);

    // R2 invert d3 bounds: master1 loses access
    progDesc(3, 23'h0007FF, 23'h000000, 3'b111, 1'b0, 1'b0);
    drive(2'd1, 1'b0, 23'h000018, 1'b0, 1'b0, v);
    check(v == 1'b1, "R2 reprogrammed inverted", 32'(v), 1);
    // R1 new descriptor effective next cycle
    progDesc(7, 23'h000000, 23'h0007FF, 3'b010, 1'b0, 1'b0);
    drive(2'd1, 1'b0, 23'h000018, 1'b1, 1'b0, v);
    check(v == 1'b0, "R1 new descriptor active", 32'(v), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule